// File: doc/BRIEF.md
# Byte-Addressable AXI4-Lite Control Register

This block is an AXI4-Lite subordinate that owns one 32-bit control register. The register carries four one-bit controls, one at the lowest bit of each byte. The control in byte 0 is a one-shot: software writes 1 to it and the hardware sees a single-cycle pulse. The other three are ordinary level controls that keep their value until they are rewritten.

Address decode compares only the word part of the address, so bits [1:0] are ignored. A CPU that issues byte-wide stores, with the byte address placed on AWADDR, still reaches the register through any of its four lanes. Write data is merged under WSTRB, so every lane is written or left alone on its own. An address outside the register's four-byte window gets an OKAY response and touches nothing.

All five channels use valid/ready. A transfer takes place on a clock edge where both VALID and READY are high. The subordinate holds BVALID and RVALID, together with their payloads, until the manager accepts them. It holds AWREADY, WREADY and ARREADY low while it has a transfer it cannot yet take. AW and W may arrive in either order or on the same edge.

Top module: `ctlreg_axil_slave`

## Requirements
- R1: After a synchronous reset with `aresetn` low, all four controls are 0, BVALID and RVALID are 0, and AWREADY, WREADY and ARREADY are 1.
- R2: Address bits [1:0] are ignored. Addresses 0x20, 0x21, 0x22 and 0x23 all select the control register.
- R3: In an accepted write that hits the register, each lane i (1 to 3) whose WSTRB bit i is set loads `ctl_fields[i]` from WDATA bit 8*i.
- R4: A lane whose WSTRB bit is 0 keeps its control unchanged.
- R5: Writing 1 to WDATA bit 0 with WSTRB bit 0 set raises `ctl_fields[0]` for exactly one clock cycle, on the same edge that raises BVALID. It then returns to 0 by itself. No other write pulses it.
- R6: A write is applied only once both AW and W have been accepted, in either order. BVALID then rises on the next edge with BRESP = 2'b00 (OKAY) and stays high until BREADY.
- R7: A read that hits the register returns bit 8*i = control i for i = 1 to 3, and 0 in every other bit, including bit 0. RRESP is 2'b00. RVALID and RDATA are held until RREADY.
- R8: Accesses outside the window complete with OKAY. Such a write changes no control and fires no pulse. Such a read returns 0.
- R9: Only one write and one read may be outstanding at a time. AWREADY and WREADY are 0 while BVALID is 1, and ARREADY is 0 while RVALID is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Synchronous reset, active low |
| s_awaddr | input | ADDR_W (8) | Write address, byte granular |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W (32) | Write data |
| s_wstrb | input | DATA_W/8 (4) | Write byte-lane enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W (8) | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W (32) | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| ctl_fields | output | DATA_W/8 (4) | Controls to hardware; bit i is the control at data bit 8*i, bit 0 is the pulse |

## Verification
The hardest case to reach from the ports is a write whose data arrives several cycles before its address. In that case the register must not change, and no pulse may fire, until the address handshake completes. The bench gets there by raising WVALID alone and holding AWVALID back for a set number of cycles. It then keeps BREADY low for a few cycles, so that it can observe the held response and the closed address and data channels. Lane isolation is reached by driving byte addresses 0x21 to 0x23 with single-bit strobes and all-ones data. A later read then shows that only the strobed lane moved.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam int unsigned LANE_BITS = 8;
endpackage

// File: rtl/ctlreg_wr_chan.sv
module ctlreg_wr_chan #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output logic [LANES-1:0]  commit_strb
);
  import ctlreg_pkg::*;

  logic              aw_held, w_held, bvalid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [LANES-1:0]  strb_q;

  assign awready = !aw_held && !bvalid_q;
  assign wready  = !w_held && !bvalid_q;
  assign commit  = aw_held && w_held && !bvalid_q;
  assign bvalid  = bvalid_q;
  assign bresp   = RESP_OKAY;
  assign commit_addr = addr_q;
  assign commit_data = data_q;
  assign commit_strb = strb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_held  <= 1'b0;
      w_held   <= 1'b0;
      bvalid_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      strb_q   <= '0;
    end else begin
      if (awvalid && awready) begin
        aw_held <= 1'b1;
        addr_q  <= awaddr;
      end
      if (wvalid && wready) begin
        w_held <= 1'b1;
        data_q <= wdata;
        strb_q <= wstrb;
      end
      if (commit) begin
        aw_held  <= 1'b0;
        w_held   <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid); // R6
  AST_BRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> bresp == 2'b00); // R6
  AST_ONE_WRITE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !awready && !wready); // R9
  AST_COMMIT_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid) |-> !awready && !wready); // R6
endmodule

// File: rtl/ctlreg_rd_chan.sv
module ctlreg_rd_chan #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic [ADDR_W-1:0] lookup_addr,
  input  logic              lookup_hit,
  input  logic [DATA_W-1:0] lookup_word
);
  import ctlreg_pkg::*;

  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign arready     = !rvalid_q;
  assign rvalid      = rvalid_q;
  assign rdata       = rdata_q;
  assign rresp       = RESP_OKAY;
  assign lookup_addr = araddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid && arready) begin
      rvalid_q <= 1'b1;
      rdata_q  <= lookup_hit ? lookup_word : '0;
    end else if (rvalid_q && rready) begin
      rvalid_q <= 1'b0;
    end
  end

  AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata)); // R7
  AST_ONE_READ_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> !arready); // R9
  AST_READ_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && arready && !lookup_hit |=> rdata == '0); // R8
  AST_RRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> rresp == 2'b00); // R7
endmodule

// File: rtl/ctlreg_fields.sv
module ctlreg_fields #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hit,
  input  logic [LANES-1:0]  wr_lsb,
  input  logic [LANES-1:0]  wr_strb,
  output logic [LANES-1:0]  fields,
  output logic [DATA_W-1:0] rd_word
);
  import ctlreg_pkg::*;

  logic lane_we [LANES];

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      assign lane_we[gi] = wr_en && wr_hit && wr_strb[gi];
      if (gi == 0) begin : g_pulse
        always_ff @(posedge clk) begin
          if (!rst_n) fields[gi] <= 1'b0;
          else        fields[gi] <= lane_we[gi] && wr_lsb[gi];
        end
        AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
          fields[gi] |=> !fields[gi]); // R5
        AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
          !lane_we[gi] |=> !fields[gi]); // R5
      end else begin : g_level
        always_ff @(posedge clk) begin
          if (!rst_n)           fields[gi] <= 1'b0;
          else if (lane_we[gi]) fields[gi] <= wr_lsb[gi];
        end
        AST_LANE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
          !lane_we[gi] |=> $stable(fields[gi])); // R4
      end
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    for (int i = 1; i < LANES; i++) rd_word[i*LANE_BITS] = fields[i];
  end
endmodule

// File: rtl/ctlreg_axil_slave.sv
module ctlreg_axil_slave #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h20,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned LSB_W = $clog2(LANES)
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [LANES-1:0]  s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [LANES-1:0]  ctl_fields
);
  logic              commit;
  logic [ADDR_W-1:0] c_addr, r_addr;
  logic [DATA_W-1:0] c_data, word;
  logic [LANES-1:0]  c_strb, c_lsb;
  logic              wr_hit, rd_hit;
  logic              unused_bits;

  ctlreg_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(aclk), .rst_n(aresetn),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .commit(commit), .commit_addr(c_addr), .commit_data(c_data), .commit_strb(c_strb)
  );

  ctlreg_rd_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(aclk), .rst_n(aresetn),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .lookup_addr(r_addr), .lookup_hit(rd_hit), .lookup_word(word)
  );

  // word-granular decode: byte offset inside the word is dropped
  assign wr_hit = (c_addr[ADDR_W-1:LSB_W] == REG_OFFSET[ADDR_W-1:LSB_W]);
  assign rd_hit = (r_addr[ADDR_W-1:LSB_W] == REG_OFFSET[ADDR_W-1:LSB_W]);

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lsb
      assign c_lsb[gl] = c_data[gl*8];
    end
  endgenerate

  assign unused_bits = ^{c_data, c_addr[LSB_W-1:0], r_addr[LSB_W-1:0]};

  ctlreg_fields #(.DATA_W(DATA_W)) u_fields (
    .clk(aclk), .rst_n(aresetn),
    .wr_en(commit), .wr_hit(wr_hit), .wr_lsb(c_lsb), .wr_strb(c_strb),
    .fields(ctl_fields), .rd_word(word)
  );

  AST_MISS_WRITE_NO_PULSE: assert property (@(posedge aclk) disable iff (!aresetn)
    commit && !wr_hit |=> !ctl_fields[0]); // R8
  AST_PULSE_WITH_RESPONSE: assert property (@(posedge aclk) disable iff (!aresetn)
    ctl_fields[0] |-> $rose(s_bvalid)); // R5
endmodule

// File: tb/tb_ctlreg_axil_slave.sv
`timescale 1ns/1ps
module tb_ctlreg_axil_slave;
  logic aclk = 1'b0;
  logic aresetn = 1'b0;
  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [3:0]  ctl_fields;

  int checks = 0;
  int failures = 0;

  always #2.5 aclk = ~aclk;

  ctlreg_axil_slave dut (
    .aclk(aclk), .aresetn(aresetn),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .ctl_fields(ctl_fields)
  );

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [3:0]  ws;
    logic [7:0]  ra;
    logic [31:0] exp_rd;
    logic        exp_pulse;
  } vec_t;

  localparam vec_t VEC [0:9] = '{
    '{8'h20, 32'h0101_0101, 4'hF, 8'h20, 32'h0101_0100, 1'b1},
    '{8'h23, 32'h0000_0000, 4'h8, 8'h21, 32'h0001_0100, 1'b0},
    '{8'h22, 32'h0000_0000, 4'h4, 8'h22, 32'h0000_0100, 1'b0},
    '{8'h21, 32'h0000_0000, 4'h2, 8'h23, 32'h0000_0000, 1'b0},
    '{8'h21, 32'hFFFF_FFFF, 4'h2, 8'h20, 32'h0000_0100, 1'b0},
    '{8'h20, 32'h0100_0001, 4'h1, 8'h20, 32'h0000_0100, 1'b1},
    '{8'h24, 32'hFFFF_FFFF, 4'hF, 8'h20, 32'h0000_0100, 1'b0},
    '{8'h1C, 32'hFFFF_FFFF, 4'hF, 8'h22, 32'h0000_0100, 1'b0},
    '{8'h20, 32'h0101_0100, 4'hE, 8'h20, 32'h0101_0100, 1'b0},
    '{8'h20, 32'h00FF_00FF, 4'hE, 8'h20, 32'h0001_0000, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int w_lead, input int bhold,
                          output logic pulse, output logic [1:0] resp);
    int n = 0;
    bit ad = 0, wd = 0;
    @(negedge aclk);
    awaddr = a; wdata = d; wstrb = s;
    wvalid = 1'b1;
    awvalid = (w_lead == 0);
    while (!(ad && wd)) begin
      bit ah, wh;
      ah = awvalid && awready;
      wh = wvalid && wready;
      @(posedge aclk);
      @(negedge aclk);
      if (ah) begin ad = 1; awvalid = 1'b0; end
      if (wh) begin wd = 1; wvalid = 1'b0; end
      n++;
      if (!ad && n >= w_lead) begin
        if (w_lead > 0 && !awvalid)
          check(ctl_fields == 4'h0 || ctl_fields[0] == 1'b0, "R6 no pulse before AW", {28'd0, ctl_fields}, 32'd0);
        awvalid = 1'b1;
      end
    end
    while (!bvalid) @(negedge aclk);
    pulse = ctl_fields[0];
    resp = bresp;
    if (bhold > 0) begin
      repeat (bhold) @(negedge aclk);
      check(bvalid == 1'b1, "R6 bvalid held without bready", {31'd0, bvalid}, 32'd1);
      check(awready == 1'b0 && wready == 1'b0, "R9 aw/w closed while bvalid",
            {30'd0, awready, wready}, 32'd0);
    end
    bready = 1'b1;
    @(negedge aclk);
    bready = 1'b0;
    check(ctl_fields[0] == 1'b0, "R5 pulse lasts one cycle", {31'd0, ctl_fields[0]}, 32'd0);
    check(bvalid == 1'b0, "R6 bvalid drops after bready", {31'd0, bvalid}, 32'd0);
  endtask

  task automatic do_read(input logic [7:0] a, input int rhold,
                         output logic [31:0] d, output logic [1:0] resp);
    bit done = 0;
    @(negedge aclk);
    araddr = a;
    arvalid = 1'b1;
    while (!done) begin
      bit h;
      h = arvalid && arready;
      @(posedge aclk);
      @(negedge aclk);
      if (h) begin done = 1; arvalid = 1'b0; end
    end
    while (!rvalid) @(negedge aclk);
    d = rdata;
    resp = rresp;
    if (rhold > 0) begin
      repeat (rhold) @(negedge aclk);
      check(rvalid == 1'b1 && rdata == d, "R7 rvalid/rdata held", rdata, d);
      check(arready == 1'b0, "R9 ar closed while rvalid", {31'd0, arready}, 32'd0);
    end
    rready = 1'b1;
    @(negedge aclk);
    rready = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic p;
    logic [1:0] r;
    logic [31:0] d;

    repeat (4) @(negedge aclk);
    check(ctl_fields == 4'h0, "R1 fields reset", {28'd0, ctl_fields}, 32'd0);
    check(bvalid == 1'b0 && rvalid == 1'b0, "R1 valids reset", {30'd0, bvalid, rvalid}, 32'd0);
    aresetn = 1'b1;
    @(negedge aclk);
    check(awready && wready && arready, "R1 readies after reset",
          {29'd0, awready, wready, arready}, 32'd7);
    do_read(8'h20, 0, d, r);
    check(d == 32'd0, "R1 register reads zero after reset", d, 32'd0);

    for (int i = 0; i < 10; i++) begin
      do_write(VEC[i].wa, VEC[i].wd, VEC[i].ws, 0, 0, p, r);
      check(p == VEC[i].exp_pulse, $sformatf("R5 pulse vec%0d", i), {31'd0, p}, {31'd0, VEC[i].exp_pulse});
      check(r == 2'b00, $sformatf("R6 bresp vec%0d", i), {30'd0, r}, 32'd0);
      do_read(VEC[i].ra, 0, d, r);
      check(d == VEC[i].exp_rd, $sformatf("R2 R3 R4 R8 readback vec%0d", i), d, VEC[i].exp_rd);
      check(r == 2'b00, $sformatf("R7 rresp vec%0d", i), {30'd0, r}, 32'd0);
      check(ctl_fields[3:1] == {VEC[i].exp_rd[24], VEC[i].exp_rd[16], VEC[i].exp_rd[8]},
            $sformatf("R3 field pins vec%0d", i), {29'd0, ctl_fields[3:1]},
            {29'd0, VEC[i].exp_rd[24], VEC[i].exp_rd[16], VEC[i].exp_rd[8]});
    end

    // R8: read outside the window returns zero with OKAY
    do_read(8'h24, 0, d, r);
    check(d == 32'd0, "R8 miss read zero", d, 32'd0);
    check(r == 2'b00, "R8 miss read okay", {30'd0, r}, 32'd0);

    // R6: data leads the address by four cycles, response held for three
    do_write(8'h23, 32'h0100_0000, 4'h8, 4, 3, p, r);
    check(p == 1'b0, "R6 W-first write no pulse", {31'd0, p}, 32'd0);
    check(r == 2'b00, "R6 W-first bresp", {30'd0, r}, 32'd0);
    do_read(8'h20, 3, d, r);
    check(d == 32'h0101_0000, "R6 W-first write applied", d, 32'h0101_0000);

    // R5: data-first one-shot write pulses once
    do_write(8'h22, 32'h0000_0001, 4'h1, 2, 0, p, r);
    check(p == 1'b1, "R5 W-first pulse", {31'd0, p}, 32'd1);

    // R1: reset clears the controls again
    @(negedge aclk);
    aresetn = 1'b0;
    @(negedge aclk);
    aresetn = 1'b1;
    @(negedge aclk);
    check(ctl_fields == 4'h0, "R1 fields cleared by reset", {28'd0, ctl_fields}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule